// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block sits in the execute stage of a five-stage in-order pipeline and chooses, for each of the two ALU operands, where its value comes from. The candidates are the value read from the register file during decode, the ALU result one stage ahead, and the value about to be written back two stages ahead. Each choice is made by comparing the operand's source register number with the destination register numbers of the two older instructions still in flight. The comparison only counts when that older instruction writes a register, and never when it writes register zero.

When both older stages target the operand's register, the younger instruction's result is used, because it is the most recent value of that register. The block is purely combinational. It drives a 2-bit select per operand, and a pair of operand multiplexers turns those selects into the forwarded operand values.

Top module: `fwd_unit`

## Requirements
- R1: When neither older stage gives a valid match for an operand, its select is 2'b00 and the operand output equals its register-file input.
- R2: A valid match in the stage one ahead (write enable high, destination non-zero, destination equal to the source number) sets the select to 2'b10 and passes that stage's ALU result.
- R3: A valid match in the stage two ahead, with no valid match one ahead, sets the select to 2'b01 and passes the writeback value.
- R4: When both stages validly match the same operand, the stage one ahead wins (select 2'b10).
- R5: A stage whose write enable is low never supplies an operand, even if its destination matches.
- R6: A stage whose destination is register 0 never supplies an operand, including when the source number is also 0.
- R7: A destination match one ahead whose write enable is low does not block a valid match two ahead.
- R8: The first operand is matched against the first source number and the second against the second source number, independently, so the two operands may come from different stages.
- R9: The select code 2'b11 is never driven. An operand multiplexer that sees it passes the register-file value.
- R10: Selects and operands settle within the same cycle as the inputs that cause them; there is no storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rs_i | input | REG_W | Source register number of the first operand |
| rt_i | input | REG_W | Source register number of the second operand |
| rf_a_i | input | DATA_W | Register-file value of the first operand |
| rf_b_i | input | DATA_W | Register-file value of the second operand |
| exm_rd_i | input | REG_W | Destination register number one stage ahead |
| exm_we_i | input | 1 | Register write enable one stage ahead |
| exm_alu_i | input | DATA_W | ALU result one stage ahead |
| mwb_rd_i | input | REG_W | Destination register number two stages ahead |
| mwb_we_i | input | 1 | Register write enable two stages ahead |
| mwb_wdata_i | input | DATA_W | Writeback value two stages ahead |
| sel_a_o | output | 2 | Source select of the first operand (00 file, 10 one ahead, 01 two ahead) |
| sel_b_o | output | 2 | Source select of the second operand, same coding |
| opnd_a_o | output | DATA_W | Forwarded first operand |
| opnd_b_o | output | DATA_W | Forwarded second operand |

## Verification
The hardest cases are the ones where a stage matches but must not win: a same-register match one ahead with its write enable low, which must leave the way open to the older stage, and register 0 targeted by both stages at once. Directed vectors build each of these, together with both operands drawn from opposite stages in one cycle. A random phase then limits register numbers to 0..3, so matches, double matches and zero destinations occur often.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SRC_RF = 2'b00,
    SRC_WB = 2'b01,
    SRC_EX = 2'b10
  } src_sel_e;

  localparam int unsigned N_OPND = 2;
endpackage

// File: rtl/fwd_hit.sv
module fwd_hit #(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] src_i,
  input  logic [REG_W-1:0] rd_i,
  input  logic             we_i,
  output logic             hit_o
);
  // register 0 is hardwired, never a bypass source
  assign hit_o = we_i && (rd_i != '0) && (rd_i == src_i);
endmodule

// File: rtl/fwd_lane.sv
module fwd_lane
  import fwd_pkg::*;
#(
  parameter int unsigned REG_W  = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic [REG_W-1:0]  src_i,
  input  logic [DATA_W-1:0] rf_i,
  input  logic [REG_W-1:0]  exm_rd_i,
  input  logic              exm_we_i,
  input  logic [DATA_W-1:0] exm_alu_i,
  input  logic [REG_W-1:0]  mwb_rd_i,
  input  logic              mwb_we_i,
  input  logic [DATA_W-1:0] mwb_wdata_i,
  output logic [1:0]        sel_o,
  output logic [DATA_W-1:0] opnd_o
);
  logic ex_hit, wb_hit;
  logic [1:0] sel;

  fwd_hit #(.REG_W(REG_W)) u_ex_hit (
    .src_i(src_i), .rd_i(exm_rd_i), .we_i(exm_we_i), .hit_o(ex_hit)
  );
  fwd_hit #(.REG_W(REG_W)) u_wb_hit (
    .src_i(src_i), .rd_i(mwb_rd_i), .we_i(mwb_we_i), .hit_o(wb_hit)
  );

  // younger stage holds the newest value
  always_comb begin
    if (ex_hit)      sel = SRC_EX;
    else if (wb_hit) sel = SRC_WB;
    else             sel = SRC_RF;
  end

  always_comb begin
    unique case (sel)
      SRC_EX:  opnd_o = exm_alu_i;
      SRC_WB:  opnd_o = mwb_wdata_i;
      default: opnd_o = rf_i;
    endcase
  end

  assign sel_o = sel;
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int unsigned REG_W  = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic [REG_W-1:0]  rs_i,
  input  logic [REG_W-1:0]  rt_i,
  input  logic [DATA_W-1:0] rf_a_i,
  input  logic [DATA_W-1:0] rf_b_i,
  input  logic [REG_W-1:0]  exm_rd_i,
  input  logic              exm_we_i,
  input  logic [DATA_W-1:0] exm_alu_i,
  input  logic [REG_W-1:0]  mwb_rd_i,
  input  logic              mwb_we_i,
  input  logic [DATA_W-1:0] mwb_wdata_i,
  output logic [1:0]        sel_a_o,
  output logic [1:0]        sel_b_o,
  output logic [DATA_W-1:0] opnd_a_o,
  output logic [DATA_W-1:0] opnd_b_o
);
  logic [REG_W-1:0]  src_w  [N_OPND];
  logic [DATA_W-1:0] rf_w   [N_OPND];
  logic [1:0]        sel_w  [N_OPND];
  logic [DATA_W-1:0] opnd_w [N_OPND];

  assign src_w[0] = rs_i;
  assign src_w[1] = rt_i;
  assign rf_w[0]  = rf_a_i;
  assign rf_w[1]  = rf_b_i;

  for (genvar g = 0; g < N_OPND; g++) begin : g_lane
    fwd_lane #(.REG_W(REG_W), .DATA_W(DATA_W)) u_lane (
      .src_i      (src_w[g]),
      .rf_i       (rf_w[g]),
      .exm_rd_i   (exm_rd_i),
      .exm_we_i   (exm_we_i),
      .exm_alu_i  (exm_alu_i),
      .mwb_rd_i   (mwb_rd_i),
      .mwb_we_i   (mwb_we_i),
      .mwb_wdata_i(mwb_wdata_i),
      .sel_o      (sel_w[g]),
      .opnd_o     (opnd_w[g])
    );
  end

  assign sel_a_o  = sel_w[0];
  assign sel_b_o  = sel_w[1];
  assign opnd_a_o = opnd_w[0];
  assign opnd_b_o = opnd_w[1];
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int unsigned REG_W  = 5,
  parameter int unsigned DATA_W = 32
) (
  input logic [REG_W-1:0]  rs_i,
  input logic [REG_W-1:0]  rt_i,
  input logic [DATA_W-1:0] rf_a_i,
  input logic [DATA_W-1:0] rf_b_i,
  input logic [REG_W-1:0]  exm_rd_i,
  input logic              exm_we_i,
  input logic [DATA_W-1:0] exm_alu_i,
  input logic [REG_W-1:0]  mwb_rd_i,
  input logic              mwb_we_i,
  input logic [DATA_W-1:0] mwb_wdata_i,
  input logic [1:0]        sel_a_o,
  input logic [1:0]        sel_b_o,
  input logic [DATA_W-1:0] opnd_a_o,
  input logic [DATA_W-1:0] opnd_b_o
);
  always_comb begin
    a_r9_no_code11: assert (sel_a_o != 2'b11 && sel_b_o != 2'b11)
      else $error("select code 11 driven");
    if (sel_a_o == 2'b00)
      a_r1_file_a: assert (opnd_a_o == rf_a_i) else $error("operand a not file value");
    if (sel_b_o == 2'b00)
      a_r1_file_b: assert (opnd_b_o == rf_b_i) else $error("operand b not file value");
    if (sel_a_o == 2'b10)
      a_r2_ex_a: assert (opnd_a_o == exm_alu_i) else $error("operand a not ALU result");
    if (sel_b_o == 2'b10)
      a_r2_ex_b: assert (opnd_b_o == exm_alu_i) else $error("operand b not ALU result");
    if (sel_a_o == 2'b01)
      a_r3_wb_a: assert (opnd_a_o == mwb_wdata_i) else $error("operand a not writeback");
    if (sel_b_o == 2'b01)
      a_r3_wb_b: assert (opnd_b_o == mwb_wdata_i) else $error("operand b not writeback");
    if (exm_we_i && exm_rd_i != '0 && exm_rd_i == rs_i)
      a_r4_ex_wins_a: assert (sel_a_o == 2'b10) else $error("ex priority lost on a");
    if (!exm_we_i && !mwb_we_i)
      a_r5_no_we: assert (sel_a_o == 2'b00 && sel_b_o == 2'b00)
        else $error("forward without write enable");
    if (rs_i == '0)
      a_r6_zero_a: assert (sel_a_o == 2'b00) else $error("register 0 forwarded on a");
    if (rt_i == '0)
      a_r6_zero_b: assert (sel_b_o == 2'b00) else $error("register 0 forwarded on b");
  end
endmodule

bind fwd_unit fwd_unit_chk #(.REG_W(REG_W), .DATA_W(DATA_W)) chk_i (
  .rs_i(rs_i), .rt_i(rt_i), .rf_a_i(rf_a_i), .rf_b_i(rf_b_i),
  .exm_rd_i(exm_rd_i), .exm_we_i(exm_we_i), .exm_alu_i(exm_alu_i),
  .mwb_rd_i(mwb_rd_i), .mwb_we_i(mwb_we_i), .mwb_wdata_i(mwb_wdata_i),
  .sel_a_o(sel_a_o), .sel_b_o(sel_b_o), .opnd_a_o(opnd_a_o), .opnd_b_o(opnd_b_o)
);

// File: tb/fwd_unit_tb_top.sv
module fwd_unit_tb_top;
  localparam int unsigned REG_W  = 5;
  localparam int unsigned DATA_W = 32;

  typedef struct {
    string             tag;
    logic [1:0]        sa;
    logic [1:0]        sb;
    logic [DATA_W-1:0] oa;
    logic [DATA_W-1:0] ob;
  } exp_t;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [REG_W-1:0]  rs, rt, exm_rd, mwb_rd;
  logic [DATA_W-1:0] rf_a, rf_b, exm_alu, mwb_wdata;
  logic              exm_we, mwb_we;
  logic [1:0]        sel_a, sel_b;
  logic [DATA_W-1:0] opnd_a, opnd_b;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;
  exp_t q[$];

  fwd_unit #(.REG_W(REG_W), .DATA_W(DATA_W)) dut_i (
    .rs_i(rs), .rt_i(rt), .rf_a_i(rf_a), .rf_b_i(rf_b),
    .exm_rd_i(exm_rd), .exm_we_i(exm_we), .exm_alu_i(exm_alu),
    .mwb_rd_i(mwb_rd), .mwb_we_i(mwb_we), .mwb_wdata_i(mwb_wdata),
    .sel_a_o(sel_a), .sel_b_o(sel_b), .opnd_a_o(opnd_a), .opnd_b_o(opnd_b)
  );

  // spec: 10 one ahead, 01 two ahead, 00 file; one ahead wins
  function automatic logic [1:0] pick(logic [REG_W-1:0] src, logic [REG_W-1:0] erd,
                                      logic ewe, logic [REG_W-1:0] mrd, logic mwe);
    if (ewe && erd != 0 && erd == src) return 2'b10;
    if (mwe && mrd != 0 && mrd == src) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [DATA_W-1:0] route(logic [1:0] s, logic [DATA_W-1:0] rf);
    case (s)
      2'b10:   return exm_alu;
      2'b01:   return mwb_wdata;
      default: return rf;
    endcase
  endfunction

  task automatic drive(string tag, logic [REG_W-1:0] a, logic [REG_W-1:0] b,
                       logic [REG_W-1:0] erd, logic ewe,
                       logic [REG_W-1:0] mrd, logic mwe);
    exp_t e;
    @(negedge clk);
    rs = a; rt = b; exm_rd = erd; exm_we = ewe; mwb_rd = mrd; mwb_we = mwe;
    rf_a = $urandom; rf_b = $urandom; exm_alu = $urandom; mwb_wdata = $urandom;
    e.tag = tag;
    e.sa  = pick(a, erd, ewe, mrd, mwe);
    e.sb  = pick(b, erd, ewe, mrd, mwe);
    e.oa  = route(e.sa, rf_a);
    e.ob  = route(e.sb, rf_b);
    q.push_back(e);
  endtask

  // monitor: one vector per cycle, sampled half a period after drive
  initial begin
    forever begin
      @(posedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        vectors++;
        if (sel_a !== e.sa || sel_b !== e.sb || opnd_a !== e.oa || opnd_b !== e.ob) begin
          miscompares++;
          $display("FAIL %s: sel_a=%b sel_b=%b opnd_a=%h opnd_b=%h expected %b %b %h %h",
                   e.tag, sel_a, sel_b, opnd_a, opnd_b, e.sa, e.sb, e.oa, e.ob);
        end
      end
    end
  end

  initial begin
    rs = 0; rt = 0; exm_rd = 0; exm_we = 0; mwb_rd = 0; mwb_we = 0;
    rf_a = 0; rf_b = 0; exm_alu = 0; mwb_wdata = 0;
    drive("R1 idle inputs", 0, 0, 0, 0, 0, 0);
    drive("R1 no match", 3, 4, 8, 1, 9, 1);
    drive("R2 ex match on a", 3, 4, 3, 1, 0, 0);
    drive("R3 wb match on b", 3, 4, 0, 0, 4, 1);
    drive("R4 same reg both stages", 7, 7, 7, 1, 7, 1);
    drive("R7 ex match we low", 7, 2, 7, 0, 7, 1);
    drive("R5 both we low", 7, 7, 7, 0, 7, 0);
    drive("R6 register 0 all", 0, 0, 0, 1, 0, 1);
    drive("R6 ex rd0 wb valid", 0, 5, 0, 1, 5, 1);
    drive("R8 a ex b wb", 5, 9, 5, 1, 9, 1);
    drive("R8 a wb b ex", 9, 5, 5, 1, 9, 1);
    drive("R8 both ex", 6, 6, 6, 1, 2, 1);
    drive("R10 same cycle change", 6, 6, 1, 1, 6, 1);
    for (int i = 0; i < 400; i++)
      drive("R9 random", REG_W'($urandom_range(0, 3)), REG_W'($urandom_range(0, 3)),
            REG_W'($urandom_range(0, 3)), 1'($urandom), REG_W'($urandom_range(0, 3)),
            1'($urandom));
    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule